// File: doc/BRIEF.md
# Serial-Memory Control Register with Protected Commit

This block holds the write-control and block-protection state of a two-wire serial memory slave. A bus front end, outside this block, turns the SDA/SCL activity into single-cycle events: a start condition, a stop condition, a received byte (with its position in the transaction and its value) and a request for a read byte. For every received byte the block gives an acknowledge decision one cycle later. For read requests that reach the register it returns the register byte.

The register sits at word address 0xFFFF. Only a byte write or a random read to that address reaches it. Two volatile enable latches guard it: one for writes in general, and one for the protection bits. Changing the protection bits takes three transactions: set the write enable, set the register enable, then write the protection byte. The last step is committed only at the following stop. The commit runs as a timed busy interval, and the block refuses the bus for the whole interval. The block also tells the address-pointer logic when the pointer becomes undefined, after a register write, and when it must be cleared, after a register read.

Top module: `eep_cr_reg`

## Requirements
- R1: After reset the write-enable and register-enable latches are 0. The protect-enable and block-protect outputs are 0. Busy is low, and no acknowledge, read or pointer pulse is present.
- R2: A register data byte of 0x02 is acknowledged even while the write enable is 0. At the following stop it sets the write enable to 1.
- R3: While the write enable is 0, every other data byte (to the array or to the register) is not acknowledged and changes no state.
- R4: A register data byte of 0x06 with the write enable at 1 sets the register enable at the following stop. With the write enable at 0 it is not acknowledged and has no effect.
- R5: A register write transaction accepts only its first data byte. Every later data byte in it is not acknowledged.
- R6: With both latches at 1, a register data byte whose bit 2 is 0 is acknowledged. The stop that follows starts a busy interval of exactly NV_CYCLES cycles. When busy falls, protect-enable takes bit 7, block-protect[2] takes bit 0, block-protect[1] takes bit 4, block-protect[0] takes bit 3, and both latches clear.
- R7: While busy is high, a slave address byte (byte index 0) is not acknowledged. When idle, it is acknowledged.
- R8: Latch and protection changes happen only at a stop. A start that arrives after the data byte and before the stop discards the pending change. A transaction that ends before its data byte changes nothing.
- R9: A read transaction that follows a write of address 0xFFFF under a repeated start returns one register byte. Its layout is bit 7 protect-enable, bits 6 and 5 zero, bit 4 block-protect[1], bit 3 block-protect[0], bit 2 register enable, bit 1 write enable, bit 0 block-protect[2]. The pointer-clear pulse comes with that byte. Later read requests in the same transaction return nothing.
- R10: A pointer-undefined pulse appears one cycle after a stop that applies an accepted register write, and never otherwise.
- R11: A data byte sent to any address other than 0xFFFF is acknowledged exactly when the write enable is 1. A read after such an address returns no register byte.
- R12: A register data byte of 0x00 with the write enable at 1 (and the register enable at 0) clears both latches at the following stop.
- R13: The acknowledge strobe is high exactly in the cycle after each received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start or repeated-start condition seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_byte | input | 1 | A byte was received from the master |
| byte_idx | input | IDX_W | Position of the byte in the transaction: 0 slave address, 1 and 2 word address, 3 and up data (saturating) |
| byte_data | input | 8 | Received byte value; bit 0 of the slave byte is 1 for read |
| ev_rd | input | 1 | Master requests a read byte |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_reg_vld | output | 1 | Register byte is being returned |
| rd_data | output | 8 | Register byte |
| busy | output | 1 | Nonvolatile commit in progress |
| ptr_clr | output | 1 | Address pointer must be set to zero |
| ptr_undef | output | 1 | Address pointer is now undefined |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register write-enable latch |
| wpen | output | 1 | Protect-enable bit |
| bp | output | 3 | Block-protect bits [2:0] |

## Verification
The unlock path is driven in order and out of order. Setting the register enable before the write enable, or sending protect bytes with only the write enable set, separates a correct guard from one that checks only the final latch. Multi-byte register writes and writes aborted by a repeated start or an early stop show that only the first byte is taken and that changes wait for the stop. Random mixes of array writes, register reads and the four register byte classes, checked against a reference model after every transaction, then confirm the readback layout and the exact busy length after each commit.

// File: rtl/eep_cr_pkg.sv
// Package: shared types and helpers for the control-register path.
// Assumes: register byte layout is fixed by the decoding of neighbours.
package eep_cr_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_WEL,
        OP_SET_RWEL,
        OP_CLEAR,
        OP_COMMIT
    } cr_op_e;

    localparam int POS_WPEN = 7;
    localparam int POS_BP1  = 4;
    localparam int POS_BP0  = 3;
    localparam int POS_RWEL = 2;
    localparam int POS_WEL  = 1;
    localparam int POS_BP2  = 0;

    localparam logic [7:0] CODE_SET_WEL  = 8'h02;
    localparam logic [7:0] CODE_SET_RWEL = 8'h06;
    localparam logic [7:0] CODE_CLEAR    = 8'h00;

    // Decide what a register data byte does given the current latches.
    function automatic cr_op_e classify(input logic [7:0] d,
                                        input logic wel_i,
                                        input logic rwel_i);
        cr_op_e op;
        if (wel_i && rwel_i && !d[POS_RWEL])
            op = OP_COMMIT;
        else if (d == CODE_SET_WEL)
            op = OP_SET_WEL;
        else if (wel_i && d == CODE_SET_RWEL)
            op = OP_SET_RWEL;
        else if (wel_i && d == CODE_CLEAR)
            op = OP_CLEAR;
        else
            op = OP_NONE;
        return op;
    endfunction

    // Assemble the register byte from its fields.
    function automatic logic [7:0] pack_cr(input logic wpen_i,
                                           input logic [2:0] bp_i,
                                           input logic rwel_i,
                                           input logic wel_i);
        logic [7:0] v;
        v = 8'h00;
        v[POS_WPEN] = wpen_i;
        v[POS_BP2]  = bp_i[2];
        v[POS_BP1]  = bp_i[1];
        v[POS_BP0]  = bp_i[0];
        v[POS_RWEL] = rwel_i;
        v[POS_WEL]  = wel_i;
        return v;
    endfunction

endpackage

// File: rtl/eep_cr_nvtimer.sv
// Module: busy timer standing in for the nonvolatile programming cycle.
// Assumes: nv_start never arrives while busy (the bus is refused then).
module eep_cr_nvtimer #(
    parameter int NV_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nv_start,
    output logic busy,
    output logic nv_done
);
    localparam int CNT_W = (NV_CYCLES < 2) ? 1 : $clog2(NV_CYCLES);

    logic [CNT_W-1:0] cnt;
    logic             busy_q;

    // Last busy cycle: the stored bits update on this edge.
    assign nv_done = busy_q && (cnt == '0);
    assign busy    = busy_q;

    // Count down the programming interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (nv_start) begin
            busy_q <= 1'b1;
            cnt    <= CNT_W'(NV_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt == '0)
                busy_q <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/eep_cr_latches.sv
// Module: enable latches, protection bits and the pending register write.
// Assumes: wr_fire marks an accepted register data byte; changes apply
// only at stop, a start discards them, a commit lands at nv_done.
module eep_cr_latches
    import eep_cr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic [7:0] byte_data,
    input  logic       wr_fire,
    input  logic       nv_done,
    output logic       accept,
    output logic       nv_start,
    output logic       ptr_undef,
    output logic       wel,
    output logic       rwel,
    output logic       wpen,
    output logic [2:0] bp
);
    cr_op_e     pend_op;
    logic [7:0] pend_val;
    logic [7:0] stage;

    // Acceptance of an incoming register byte under the current latches.
    assign accept   = (classify(byte_data, wel, rwel) != OP_NONE);
    // A commit begins exactly at the stop that closes its transaction.
    assign nv_start = ev_stop && (pend_op == OP_COMMIT);

    // Hold the pending operation, apply it at stop, land commits at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            rwel      <= 1'b0;
            wpen      <= 1'b0;
            bp        <= 3'b000;
            pend_op   <= OP_NONE;
            pend_val  <= 8'h00;
            stage     <= 8'h00;
            ptr_undef <= 1'b0;
        end else begin
            ptr_undef <= ev_stop && (pend_op != OP_NONE);
            if (nv_done) begin
                wpen <= stage[POS_WPEN];
                bp   <= {stage[POS_BP2], stage[POS_BP1], stage[POS_BP0]};
                wel  <= 1'b0;
                rwel <= 1'b0;
            end
            if (ev_start) begin
                pend_op <= OP_NONE;
            end else if (ev_stop) begin
                case (pend_op)
                    OP_SET_WEL:  wel  <= 1'b1;
                    OP_SET_RWEL: rwel <= 1'b1;
                    OP_CLEAR: begin
                        wel  <= 1'b0;
                        rwel <= 1'b0;
                    end
                    OP_COMMIT:   stage <= pend_val;
                    default:     ;
                endcase
                pend_op <= OP_NONE;
            end else if (wr_fire) begin
                pend_op  <= classify(byte_data, wel, rwel);
                pend_val <= byte_data;
            end
        end
    end
endmodule

// File: rtl/eep_cr_track.sv
// Module: per-transaction tracker; decides acknowledge and register reads.
// Assumes: byte_idx saturates at or above DATA_IDX; events are one-cycle
// pulses and never coincide.
module eep_cr_track
    import eep_cr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_byte,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_data,
    input  logic             ev_rd,
    input  logic             busy,
    input  logic             wel,
    input  logic             reg_accept,
    input  logic [7:0]       cr_value,
    output logic             wr_fire,
    output logic             ack_vld,
    output logic             ack,
    output logic             rd_reg_vld,
    output logic [7:0]       rd_data,
    output logic             ptr_clr
);
    localparam int ADDR_W   = 16;
    localparam int DATA_IDX = 3;
    localparam logic [ADDR_W-1:0] REG_ADDR = '1;

    logic       dead, is_rd, addr_hit, reg_rd, wr_taken;
    logic [7:0] addr_hi;
    logic       idx_slave, idx_addr, idx_data, ack_now, rd_fire;

    assign idx_slave = (byte_idx == '0);
    assign idx_data  = (byte_idx >= IDX_W'(DATA_IDX));
    assign idx_addr  = !idx_slave && !idx_data;

    // Acknowledge decision for the byte on the inputs this cycle.
    always_comb begin
        if (dead)
            ack_now = 1'b0;
        else if (idx_slave)
            ack_now = !busy;
        else if (idx_addr)
            ack_now = !is_rd;
        else
            ack_now = !is_rd && (addr_hit ? (!wr_taken && reg_accept) : wel);
    end

    assign wr_fire = ev_byte && idx_data && ack_now && addr_hit;
    assign rd_fire = ev_rd && is_rd && reg_rd && !dead;

    // Transaction state and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dead       <= 1'b0;
            is_rd      <= 1'b0;
            addr_hit   <= 1'b0;
            reg_rd     <= 1'b0;
            wr_taken   <= 1'b0;
            addr_hi    <= 8'h00;
            ack_vld    <= 1'b0;
            ack        <= 1'b0;
            rd_reg_vld <= 1'b0;
            rd_data    <= 8'h00;
            ptr_clr    <= 1'b0;
        end else begin
            ack_vld    <= ev_byte;
            ack        <= ev_byte && ack_now;
            rd_reg_vld <= rd_fire;
            ptr_clr    <= rd_fire;
            if (rd_fire)
                rd_data <= cr_value;
            if (ev_start) begin
                dead     <= 1'b0;
                reg_rd   <= 1'b0;
                wr_taken <= 1'b0;
            end else if (ev_stop) begin
                dead     <= 1'b0;
                is_rd    <= 1'b0;
                addr_hit <= 1'b0;
                reg_rd   <= 1'b0;
                wr_taken <= 1'b0;
            end else if (ev_byte) begin
                if (!ack_now)
                    dead <= 1'b1;
                if (idx_slave) begin
                    is_rd    <= byte_data[0];
                    reg_rd   <= byte_data[0] && addr_hit && !busy;
                    addr_hit <= 1'b0;
                end else if (byte_idx == IDX_W'(1)) begin
                    addr_hi <= byte_data;
                end else if (byte_idx == IDX_W'(2)) begin
                    addr_hit <= ack_now && ({addr_hi, byte_data} == REG_ADDR);
                end else if (wr_fire) begin
                    wr_taken <= 1'b1;
                end
            end else if (rd_fire) begin
                dead   <= 1'b1;
                reg_rd <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/eep_cr_reg.sv
// Module: top of the control-register path of a two-wire serial memory.
// Assumes: a bus front end supplies decoded one-cycle events; all outputs
// are registered and respond one cycle after the event.
module eep_cr_reg
    import eep_cr_pkg::*;
#(
    parameter int NV_CYCLES = 1000,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_byte,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_data,
    input  logic             ev_rd,
    output logic             ack_vld,
    output logic             ack,
    output logic             rd_reg_vld,
    output logic [7:0]       rd_data,
    output logic             busy,
    output logic             ptr_clr,
    output logic             ptr_undef,
    output logic             wel,
    output logic             rwel,
    output logic             wpen,
    output logic [2:0]       bp
);
    logic       wr_fire, reg_accept, nv_start, nv_done;
    logic [7:0] cr_value;

    // Current register image for readback.
    assign cr_value = pack_cr(wpen, bp, rwel, wel);

    eep_cr_track #(.IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .byte_idx(byte_idx), .byte_data(byte_data),
        .ev_rd(ev_rd), .busy(busy), .wel(wel),
        .reg_accept(reg_accept), .cr_value(cr_value),
        .wr_fire(wr_fire), .ack_vld(ack_vld), .ack(ack),
        .rd_reg_vld(rd_reg_vld), .rd_data(rd_data), .ptr_clr(ptr_clr)
    );

    eep_cr_latches u_latches (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_stop(ev_stop),
        .byte_data(byte_data), .wr_fire(wr_fire), .nv_done(nv_done),
        .accept(reg_accept), .nv_start(nv_start), .ptr_undef(ptr_undef),
        .wel(wel), .rwel(rwel), .wpen(wpen), .bp(bp)
    );

    eep_cr_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .nv_start(nv_start), .busy(busy), .nv_done(nv_done)
    );
endmodule

// File: rtl/eep_cr_reg_chk.sv
// Module: property checker for eep_cr_reg, attached through bind.
// Assumes: warm gates properties that look one cycle back past reset.
module eep_cr_reg_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_stop,
    input logic             ev_byte,
    input logic [IDX_W-1:0] byte_idx,
    input logic             ev_rd,
    input logic             ack_vld,
    input logic             ack,
    input logic             rd_reg_vld,
    input logic             busy,
    input logic             ptr_undef,
    input logic             wel,
    input logic             rwel,
    input logic             wpen,
    input logic [2:0]       bp
);
    logic warm;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    p_rwel_implies_wel_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        rwel |-> wel);

    p_slave_nack_busy_r7: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        (ev_byte && byte_idx == '0 && busy) |=> (ack_vld && !ack));

    p_busy_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        $rose(busy) |-> $past(ev_stop));

    p_commit_clears_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        $fell(busy) |-> (!wel && !rwel));

    p_prot_only_at_commit_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        (!$stable(bp) || !$stable(wpen)) |-> $fell(busy));

    p_latch_at_stop_r8: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        $rose(wel) |-> $past(ev_stop));

    p_undef_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ptr_undef |-> $past(ev_stop));

    p_ack_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        ack_vld |-> $past(ev_byte));

    p_read_on_request_r9: assert property (@(posedge clk) disable iff (!rst_n || !warm)
        rd_reg_vld |-> $past(ev_rd));
endmodule

bind eep_cr_reg eep_cr_reg_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .ev_byte(ev_byte),
    .byte_idx(byte_idx), .ev_rd(ev_rd), .ack_vld(ack_vld), .ack(ack),
    .rd_reg_vld(rd_reg_vld), .busy(busy), .ptr_undef(ptr_undef),
    .wel(wel), .rwel(rwel), .wpen(wpen), .bp(bp)
);

// File: tb/eep_cr_reg_bench.sv
module eep_cr_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 24;
    localparam int IW         = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_rd = 0;
    logic [IW-1:0] byte_idx = '0;
    logic [7:0] byte_data = 8'h00;
    logic ack_vld, ack, rd_reg_vld, busy, ptr_clr, ptr_undef, wel, rwel, wpen;
    logic [7:0] rd_data;
    logic [2:0] bp;

    int n_chk = 0, n_err = 0;
    bit m_wel = 0, m_rwel = 0, m_wpen = 0;
    bit [2:0] m_bp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_cr_reg #(.NV_CYCLES(NV), .IDX_W(IW)) u_eep_cr_reg (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .byte_idx(byte_idx), .byte_data(byte_data),
        .ev_rd(ev_rd), .ack_vld(ack_vld), .ack(ack), .rd_reg_vld(rd_reg_vld),
        .rd_data(rd_data), .busy(busy), .ptr_clr(ptr_clr), .ptr_undef(ptr_undef),
        .wel(wel), .rwel(rwel), .wpen(wpen), .bp(bp)
    );

    task automatic chk(input string r, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp_v);
        end
    endtask

    // Expected effect of a register byte: 0 none, 1 set wel, 2 set rwel, 3 clear, 4 commit.
    function automatic int exp_op(input logic [7:0] d, input bit w, input bit rw);
        if (w && rw && !d[2]) return 4;
        if (d == 8'h02)       return 1;
        if (w && d == 8'h06)  return 2;
        if (w && d == 8'h00)  return 3;
        return 0;
    endfunction

    function automatic logic [7:0] exp_cr();
        return {m_wpen, 2'b00, m_bp[1], m_bp[0], m_rwel, m_wel, m_bp[2]};
    endfunction

    task automatic do_start; ev_start = 1; @(negedge clk); ev_start = 0; endtask
    task automatic do_stop;  ev_stop  = 1; @(negedge clk); ev_stop  = 0; endtask

    task automatic send(input int idx, input logic [7:0] d, output bit a);
        ev_byte = 1; byte_idx = IW'(idx); byte_data = d;
        @(negedge clk);
        ev_byte = 0;
        a = ack;
        if (ack_vld !== 1'b1) chk("R13", ack_vld, 1);
    endtask

    task automatic rd(output bit v, output logic [7:0] d, output bit pc);
        ev_rd = 1; @(negedge clk); ev_rd = 0;
        v = rd_reg_vld; d = rd_data; pc = ptr_clr;
    endtask

    task automatic check_state(input string r);
        chk(r, wel, m_wel); chk(r, rwel, m_rwel);
        chk(r, wpen, m_wpen); chk(r, bp, m_bp);
    endtask

    task automatic reg_write(input logic [7:0] d, input bit extra, input bit abort, input bit probe);
        int op, c; bit a;
        op = exp_op(d, m_wel, m_rwel);
        do_start; send(0, 8'hA0, a); chk("R7", a, 1);
        send(1, 8'hFF, a); send(2, 8'hFF, a);
        send(3, d, a);
        if (op == 0) chk("R3", a, 0); else chk("R2", a, 1);
        if (extra) begin send(4, ~d, a); chk("R5", a, 0); end
        if (abort) begin
            do_start; do_stop;
            chk("R8", ptr_undef, 0);
            check_state("R8");
            return;
        end
        do_stop;
        chk("R10", ptr_undef, op != 0);
        case (op)
            1: m_wel = 1;
            2: m_rwel = 1;
            3: begin m_wel = 0; m_rwel = 0; end
            default: ;
        endcase
        if (op == 4) begin
            chk("R6", busy, 1);
            c = 0;
            if (probe) begin
                c++; do_start; c++; send(0, 8'hA0, a); chk("R7", a, 0);
                c++; do_stop; chk("R10", ptr_undef, 0);
            end
            while (busy && c < 10*NV) begin c++; @(negedge clk); end
            chk("R6", c, NV);
            m_wpen = d[7]; m_bp = {d[0], d[4], d[3]}; m_wel = 0; m_rwel = 0;
            check_state("R6");
        end else if (op == 3) begin
            check_state("R12");
        end else begin
            check_state(op == 2 ? "R4" : "R2");
        end
    endtask

    task automatic arr_write(input logic [7:0] ah, input logic [7:0] al);
        bit a;
        do_start; send(0, 8'hA0, a); send(1, ah, a); send(2, al, a);
        send(3, 8'h5A, a); chk("R11", a, m_wel);
        send(4, 8'hA5, a); chk("R11", a, m_wel);
        do_stop; chk("R10", ptr_undef, 0);
        check_state("R3");
    endtask

    task automatic rnd_read(input bit to_reg);
        bit a, v, pc; logic [7:0] d;
        do_start; send(0, 8'hA0, a);
        send(1, to_reg ? 8'hFF : 8'h12, a); send(2, to_reg ? 8'hFF : 8'h34, a);
        do_start; send(0, 8'hA1, a); chk("R7", a, 1);
        rd(v, d, pc);
        if (to_reg) begin
            chk("R9", v, 1); chk("R9", d, exp_cr()); chk("R9", pc, 1);
            rd(v, d, pc); chk("R9", v, 0);
        end else begin
            chk("R11", v, 0); chk("R11", pc, 0);
        end
        do_stop;
        check_state("R9");
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report;
        $finish;
    end

    initial begin
        bit a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        chk("R1", busy, 0); chk("R1", ack_vld, 0);
        chk("R1", rd_reg_vld, 0); chk("R1", ptr_undef, 0); chk("R1", ptr_clr, 0);

        // Out of order: register enable before write enable (R4), array with wel=0 (R3)
        reg_write(8'h06, 0, 0, 0);
        arr_write(8'h01, 8'h02);
        reg_write(8'h98, 0, 0, 0);
        // Abort before data byte leaves everything (R8)
        do_start; send(0, 8'hA0, a); send(1, 8'hFF, a); send(2, 8'hFF, a); do_stop;
        chk("R8", ptr_undef, 0); check_state("R8");
        // Unlock step one, then array write acknowledged (R11)
        reg_write(8'h02, 0, 0, 0);
        arr_write(8'hFF, 8'hFE);
        // Protect byte with only wel set is refused (R4)
        reg_write(8'h98, 0, 0, 0);
        // Step two with a trailing byte (R5), step three aborted by start (R8)
        reg_write(8'h06, 1, 0, 0);
        reg_write(8'h99, 0, 1, 0);
        // Commit with busy probe (R6, R7), then readback (R9)
        reg_write(8'h99, 1, 0, 1);
        rnd_read(1);
        rnd_read(0);
        // Clear path (R12)
        reg_write(8'h02, 0, 0, 0);
        reg_write(8'h06, 0, 0, 0);
        reg_write(8'h00, 0, 0, 0);
        reg_write(8'h02, 0, 0, 0);
        reg_write(8'h00, 0, 0, 0);

        for (int i = 0; i < 200; i++) begin
            int k; logic [7:0] d;
            k = $urandom % 7;
            case ($urandom % 5)
                0: d = 8'h02;
                1: d = 8'h06;
                2: d = 8'h00;
                3: d = 8'($urandom) & 8'hFB;
                default: d = 8'($urandom);
            endcase
            case (k)
                0, 1, 2: reg_write(d, ($urandom % 3) == 0, ($urandom % 6) == 0, ($urandom % 4) == 0);
                3: arr_write(8'($urandom % 255), 8'($urandom));
                4: rnd_read(1);
                5: rnd_read(0);
                default: begin reg_write(8'h02, 0, 0, 0); reg_write(8'h06, 0, 0, 0); end
            endcase
        end
        report;
        $finish;
    end
endmodule